// File: doc/BRIEF.md
# Serial Control Register Write Receiver

This block receives register writes over a three-wire serial link made of an active-low select, a serial clock and a serial data line. A host lowers select, sends sixteen bits on the rising edges of the serial clock, and raises select again. All three lines are sampled by a fast system clock through synchronizers, so the block needs no second clock domain. The block checks the frame when select rises. If the frame is valid for this device, the block sends a register address, a data byte and a single-cycle write strobe to a register file that sits beside it.

A frame is valid only under four conditions. Its two device-select bits must match the two strap pins. Its write flag must be set. It must hold exactly sixteen bits. Device writes must also be allowed at the moment select rises: the power-down input must be high and the master clock must be toggling. The block watches the master clock with a timeout counter. If no edge arrives within the timeout, the clock counts as absent. Reads are not supported.

Top module: `serial_reg_writer`

## Requirements
- R1: A frame is shifted in MSB first, one bit on each rising edge of `sclk_i`, with bit positions fixed. Bits 15..14 carry the device-select code (bit 15 is the high bit). Bit 13 is the write flag. Bits 12..8 carry the register address, with address bit 4 first. Bits 7..0 carry the data byte, with data bit 7 first.
- R2: A write is committed only when `csn_i` rises. With the default two synchronizer stages, `wr_en_o` is high after the third rising system clock edge that follows the rise of `csn_i`. In that same cycle `wr_addr_o` and `wr_data_o` show the frame's address and data. Both outputs then hold their value until the next accepted frame.
- R3: A frame whose write flag (bit 13) is 0 produces no strobe and leaves `wr_addr_o` and `wr_data_o` unchanged.
- R4: A frame whose device-select code differs from `strap_i` produces no strobe and leaves the outputs unchanged.
- R5: If `csn_i` rises after any number of serial clock rises other than 16 (for example 15 or 17), the frame is discarded and no strobe is produced.
- R6: A frame that closes while `pdn_ni` is low produces no strobe and leaves the outputs unchanged.
- R7: If `mclk_i` has shown no edge for `MCLK_TIMEOUT` system cycles, frames are discarded. Writes are accepted again once `mclk_i` toggles.
- R8: While reset is held and just after it ends, `wr_en_o` is 0, `wr_addr_o` is 0 and `wr_data_o` is 0.
- R9: Each accepted frame raises `wr_en_o` for exactly one system cycle. Two frames sent back to back give two strobes, and the outputs end with the second frame's values.
- R10: Serial clock edges while `csn_i` is high do not shift data. Every frame starts from an empty shift register when `csn_i` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least four times the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pdn_ni | input | 1 | Power-down, active low; blocks writes while low |
| mclk_i | input | 1 | Master clock, monitored for activity only |
| csn_i | input | 1 | Serial select, active low, idle high |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi_i | input | 1 | Serial data in |
| strap_i | input | 2 | Device-select strap pins |
| wr_en_o | output | 1 | One-cycle write strobe to the register file |
| wr_addr_o | output | 5 | Register address of the last accepted write |
| wr_data_o | output | 8 | Data byte of the last accepted write |

## Verification
Every result depends on the rise of select. The strobe and the new address and data are due in the cycle after the third system clock edge that follows that rise: two synchronizer stages, then the commit register. The bench raises select just after a falling clock edge, waits three rising edges, and samples at the next falling edge. It then checks one falling edge later that the strobe has dropped. A discarded frame has no due cycle. For those frames the bench waits a dozen cycles, then confirms that a strobe counter (updated on falling edges) is unchanged and that address and data still hold their earlier values.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int CHIP_W    = 2;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 8;
  localparam int FRAME_LEN = CHIP_W + 1 + ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);

  typedef struct packed {
    logic [CHIP_W-1:0] chip;
    logic              wr_flag;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) begin
        stage_q[i] <= RST_VAL;
      end
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/swr_mclk_mon.sv
module swr_mclk_mon #(
  parameter int TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_s_i,
  output logic mclk_ok_o
);
  localparam int TMO_W = $clog2(TIMEOUT + 1);
  localparam logic [TMO_W-1:0] TMO_MAX = TMO_W'(TIMEOUT);

  logic             mclk_q;
  logic             edge_seen;
  logic [TMO_W-1:0] idle_q, idle_d;
  logic             idle_en;
  logic             ok_q, ok_d;

  always_comb begin
    edge_seen = mclk_s_i ^ mclk_q;
    idle_en   = edge_seen | (idle_q != TMO_MAX);
    idle_d    = edge_seen ? '0 : idle_q + 1'b1;
    ok_d      = idle_en ? (idle_d != TMO_MAX) : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_q <= 1'b0;
      idle_q <= TMO_MAX;
      ok_q   <= 1'b0;
    end else begin
      mclk_q <= mclk_s_i;
      if (idle_en) idle_q <= idle_d;
      ok_q <= ok_d;
    end
  end

  assign mclk_ok_o = ok_q;
endmodule

// File: rtl/swr_deser.sv
module swr_deser
  import swr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 csn_s_i,
  input  logic                 sclk_s_i,
  input  logic                 sdi_s_i,
  output logic [FRAME_LEN-1:0] frame_o,
  output logic [CNT_W-1:0]     len_o,
  output logic                 cs_rise_o
);
  localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] LEN_OVF  = CNT_W'(FRAME_LEN + 1);

  logic                 csn_q, sclk_q;
  logic                 cs_fall, cs_rise, sclk_rise, shift_req;
  logic [FRAME_LEN-1:0] sr_q, sr_d;
  logic                 sr_en;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 cnt_en;

  always_comb begin
    cs_fall   = csn_q & ~csn_s_i;
    cs_rise   = ~csn_q & csn_s_i;
    sclk_rise = sclk_s_i & ~sclk_q;
    shift_req = ~csn_s_i & sclk_rise & ~cs_fall;

    sr_en  = cs_fall | (shift_req & (cnt_q < LEN_FULL));
    sr_d   = cs_fall ? '0 : {sr_q[FRAME_LEN-2:0], sdi_s_i};

    cnt_en = cs_fall | (shift_req & (cnt_q != LEN_OVF));
    cnt_d  = cs_fall ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q  <= 1'b1;
      sclk_q <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
    end else begin
      csn_q  <= csn_s_i;
      sclk_q <= sclk_s_i;
      if (sr_en)  sr_q  <= sr_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign frame_o   = sr_q;
  assign len_o     = cnt_q;
  assign cs_rise_o = cs_rise;
endmodule

// File: rtl/swr_commit.sv
module swr_commit
  import swr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_rise_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  input  logic [CNT_W-1:0]     len_i,
  input  logic [CHIP_W-1:0]    strap_i,
  input  logic                 pdn_ok_i,
  input  logic                 mclk_ok_i,
  output logic                 wr_en_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [DATA_W-1:0]    wr_data_o
);
  frame_t            fr;
  logic              len_ok, chip_ok, dev_ok, accept;
  logic              en_q, en_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    fr      = frame_t'(frame_i);
    len_ok  = (len_i == CNT_W'(FRAME_LEN));
    chip_ok = (fr.chip == strap_i);
    dev_ok  = pdn_ok_i & mclk_ok_i;
    accept  = cs_rise_i & len_ok & fr.wr_flag & chip_ok & dev_ok;
    en_d    = accept;
    addr_d  = fr.addr;
    data_d  = fr.data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      en_q <= en_d;
      if (accept) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign wr_en_o   = en_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/serial_reg_writer.sv
module serial_reg_writer
  import swr_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int MCLK_TIMEOUT = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pdn_ni,
  input  logic              mclk_i,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [CHIP_W-1:0] strap_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int NSYNC = 5;

  logic [1:0]           rst_pipe_q;
  logic                 rst_n;
  logic [NSYNC-1:0]     raw_in, sync_out;
  logic                 csn_s, sclk_s, sdi_s, pdn_s, mclk_s;
  logic                 mclk_ok_w;
  logic [FRAME_LEN-1:0] frame_w;
  logic [CNT_W-1:0]     bit_cnt_w;
  logic                 cs_rise_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  assign raw_in = {mclk_i, pdn_ni, sdi_i, sclk_i, csn_i};

  swr_sync #(
    .W       (NSYNC),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (5'b00001)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (raw_in),
    .q_o    (sync_out)
  );

  assign {mclk_s, pdn_s, sdi_s, sclk_s, csn_s} = sync_out;

  swr_mclk_mon #(
    .TIMEOUT (MCLK_TIMEOUT)
  ) u_mclk_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .mclk_s_i  (mclk_s),
    .mclk_ok_o (mclk_ok_w)
  );

  swr_deser u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .csn_s_i   (csn_s),
    .sclk_s_i  (sclk_s),
    .sdi_s_i   (sdi_s),
    .frame_o   (frame_w),
    .len_o     (bit_cnt_w),
    .cs_rise_o (cs_rise_w)
  );

  swr_commit u_commit (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .cs_rise_i (cs_rise_w),
    .frame_i   (frame_w),
    .len_i     (bit_cnt_w),
    .strap_i   (strap_i),
    .pdn_ok_i  (pdn_s),
    .mclk_ok_i (mclk_ok_w),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/swr_checker.sv
module swr_checker
  import swr_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [DATA_W-1:0]    wr_data,
  input logic                 cs_rise,
  input logic [CNT_W-1:0]     bit_cnt,
  input logic [FRAME_LEN-1:0] frame,
  input logic [CHIP_W-1:0]    strap,
  input logic                 pdn_ok,
  input logic                 mclk_ok
);
  assert_addr_from_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr == $past(frame[DATA_W+ADDR_W-1:DATA_W])) && (wr_data == $past(frame[DATA_W-1:0])));

  assert_strobe_on_select_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cs_rise));

  assert_outputs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ($stable(wr_addr) && $stable(wr_data)));

  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(frame[DATA_W+ADDR_W]));

  assert_chip_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(frame[FRAME_LEN-1:FRAME_LEN-CHIP_W]) == $past(strap)));

  assert_len_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(bit_cnt) == CNT_W'(FRAME_LEN)));

  assert_pdn_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(pdn_ok));

  assert_mclk_alive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(mclk_ok));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

bind serial_reg_writer swr_checker u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .wr_en   (wr_en_o),
  .wr_addr (wr_addr_o),
  .wr_data (wr_data_o),
  .cs_rise (cs_rise_w),
  .bit_cnt (bit_cnt_w),
  .frame   (frame_w),
  .strap   (strap_i),
  .pdn_ok  (pdn_s),
  .mclk_ok (mclk_ok_w)
);

// File: tb/tb_serial_reg_writer.sv
module tb_serial_reg_writer;
  localparam int HALF = 5;
  localparam int WD_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdn_n = 1'b1;
  logic       mclk = 1'b0;
  logic       mclk_run = 1'b1;
  logic       csn = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic [1:0] strap = 2'b10;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;

  int n_checks = 0;
  int n_fail = 0;
  int strobe_cnt = 0;

  always #10 clk = ~clk;
  always #33 if (mclk_run) mclk = ~mclk;

  serial_reg_writer dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pdn_ni    (pdn_n),
    .mclk_i    (mclk),
    .csn_i     (csn),
    .sclk_i    (sclk),
    .sdi_i     (sdi),
    .strap_i   (strap),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  always @(negedge clk) if (wr_en === 1'b1) strobe_cnt++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [1:0] c, logic f, logic [4:0] a, logic [7:0] d);
    return {16'h0, c, f, a, d};
  endfunction

  task automatic send_bits(input logic [31:0] w, input int n);
    @(negedge clk);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic expect_accept(input string req, input logic [4:0] a, input logic [7:0] d);
    int base;
    base = strobe_cnt;
    csn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req, "strobe due", int'(wr_en), 1);
    chk(req, "address", int'(wr_addr), int'(a));
    chk(req, "data", int'(wr_data), int'(d));
    @(negedge clk);
    chk(req, "strobe dropped", int'(wr_en), 0);
    chk(req, "strobe count", strobe_cnt, base + 1);
  endtask

  task automatic expect_ignore(input string req);
    int base;
    logic [4:0] a0;
    logic [7:0] d0;
    base = strobe_cnt;
    a0 = wr_addr;
    d0 = wr_data;
    csn = 1'b1;
    repeat (12) @(negedge clk);
    chk(req, "no strobe", strobe_cnt, base);
    chk(req, "address held", int'(wr_addr), int'(a0));
    chk(req, "data held", int'(wr_data), int'(d0));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R8", "strobe in reset", int'(wr_en), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8", "strobe after reset", int'(wr_en), 0);
    chk("R8", "address after reset", int'(wr_addr), 0);
    chk("R8", "data after reset", int'(wr_data), 0);
  endtask

  task automatic t_basic();
    send_bits(mk(2'b10, 1'b1, 5'h13, 8'hA5), 16);
    expect_accept("R2", 5'h13, 8'hA5);
  endtask

  task automatic t_patterns();
    send_bits(mk(2'b10, 1'b1, 5'h0C, 8'h3C), 16);
    expect_accept("R1", 5'h0C, 8'h3C);
    send_bits(mk(2'b10, 1'b1, 5'h1F, 8'h01), 16);
    expect_accept("R1", 5'h1F, 8'h01);
    send_bits(mk(2'b10, 1'b1, 5'h01, 8'h80), 16);
    expect_accept("R1", 5'h01, 8'h80);
  endtask

  task automatic t_flag();
    send_bits(mk(2'b10, 1'b0, 5'h07, 8'h5A), 16);
    expect_ignore("R3");
  endtask

  task automatic t_chip();
    send_bits(mk(2'b00, 1'b1, 5'h02, 8'h11), 16);
    expect_ignore("R4");
    send_bits(mk(2'b11, 1'b1, 5'h03, 8'h22), 16);
    expect_ignore("R4");
    send_bits(mk(2'b01, 1'b1, 5'h04, 8'h33), 16);
    expect_ignore("R4");
  endtask

  task automatic t_length();
    send_bits(mk(2'b10, 1'b1, 5'h0A, 8'hF0) >> 1, 15);
    expect_ignore("R5");
    send_bits({mk(2'b10, 1'b1, 5'h0B, 8'h0F), 1'b1}, 17);
    expect_ignore("R5");
    send_bits(mk(2'b10, 1'b1, 5'h0D, 8'hC3), 16);
    expect_accept("R5", 5'h0D, 8'hC3);
  endtask

  task automatic t_pdn();
    pdn_n = 1'b0;
    send_bits(mk(2'b10, 1'b1, 5'h15, 8'h99), 16);
    expect_ignore("R6");
    pdn_n = 1'b1;
    repeat (5) @(negedge clk);
    send_bits(mk(2'b10, 1'b1, 5'h16, 8'h66), 16);
    expect_accept("R6", 5'h16, 8'h66);
  endtask

  task automatic t_mclk();
    mclk_run = 1'b0;
    repeat (150) @(negedge clk);
    send_bits(mk(2'b10, 1'b1, 5'h18, 8'h77), 16);
    expect_ignore("R7");
    mclk_run = 1'b1;
    repeat (20) @(negedge clk);
    send_bits(mk(2'b10, 1'b1, 5'h19, 8'h88), 16);
    expect_accept("R7", 5'h19, 8'h88);
  endtask

  task automatic t_idle_sclk();
    sdi = 1'b1;
    for (int i = 0; i < 10; i++) begin
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    chk("R10", "no strobe while deselected", int'(wr_en), 0);
    send_bits(mk(2'b10, 1'b1, 5'h05, 8'h42), 16);
    expect_accept("R10", 5'h05, 8'h42);
  endtask

  task automatic t_back2back();
    int base;
    base = strobe_cnt;
    send_bits(mk(2'b10, 1'b1, 5'h1A, 8'hDE), 16);
    csn = 1'b1;
    repeat (4) @(negedge clk);
    send_bits(mk(2'b10, 1'b1, 5'h1B, 8'hAD), 16);
    expect_accept("R9", 5'h1B, 8'hAD);
    chk("R9", "two strobes", strobe_cnt, base + 2);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_patterns();
    t_flag();
    t_chip();
    t_length();
    t_pdn();
    t_mclk();
    t_idle_sclk();
    t_back2back();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule